// File: doc/BRIEF.md
# Video Crosspoint Routing Control Registers

This block keeps the control state for a twelve-input, nine-output analog video crosspoint. A plain write port feeds it: an 8-bit address, 8-bit data and a one-cycle strobe. The block turns the stored values into the digital control lines for the analog side.

Each output has one register. Its top bit switches the output amplifier on. When that bit is clear, the amplifier is powered down and its output floats. Two bits pick the amplifier gain. Five bits name the input that feeds the output, and zero means no input. The block decodes this register into one row of a one-hot select matrix, one enable bit and a gain code. A powered-down output always has its row cleared.

Two more registers hold one clamp-or-bias bit per input. Software sets these once to suit the kind of video wired to each input. All state resets to zero. Writes to addresses that map to no register are dropped.

Top module: `xpt_route_regs`

## Requirements
- R1: After reset, and again after any later reset, every select row, every enable, every gain code and every clamp bit is 0.
- R2: A strobed write to address 0x01+k (k = 0..8) updates only output k. The new value shows on the outputs after the clock edge that samples the strobe.
- R3: Bit 7 of an output register drives `out_en[k]`: 1 means active, 0 means powered down.
- R4: Bits 6:5 of an output register appear on `gain_code[2k+1:2k]`, with 00=6 dB, 01=7 dB, 10=8 dB and 11=9 dB. The gain code is kept even while the output is disabled.
- R5: With the output enabled, an input code n in 1..12 (bits 4:0) sets exactly bit `sel_onehot[k*12 + n-1]` of row k.
- R6: An input code of 0, any code from 13 to 31, and any code with bit 4 set leave row k all zero.
- R7: While `out_en[k]` is 0, row k is all zero whatever input code was written.
- R8: Several outputs may select the same input at once. Each row has at most one bit set.
- R9: Address 0x1D bits 7:0 set clamp bits for inputs 8..1 (`clamp_sel[7:0]`). Address 0x1E bits 3:0 set inputs 12..9 (`clamp_sel[11:8]`), and bits 7:4 of 0x1E are ignored. A 1 selects clamp and a 0 selects bias.
- R10: Writes to 0x00, 0x0A..0x1C and 0x1F..0xFF change no output.
- R11: With `wr_en` low, no output changes, whatever the address and data do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| sel_onehot | output | 108 | Row k (bits k*12+11 : k*12) is the one-hot input select of output k |
| out_en | output | 9 | Per-output amplifier enable |
| gain_code | output | 18 | Per-output 2-bit gain code, output k at bits 2k+1:2k |
| clamp_sel | output | 12 | Per-input mode: 1 clamp, 0 bias |

## Verification
Two functions can act in the same cycle: the route decode and the power-down override. A single write can carry a valid input code together with a cleared enable bit. The bench sends such writes, for example 0x45 and 0x0C. It judges the result by checking that the row stays empty while the gain field from the same byte is still taken. The bench then re-enables the output with the same code and checks that the row lights up, which shows that the override alone blanked it.

// File: rtl/xpt_route_regs.sv
module xpt_route_regs #(
  parameter int NOUT = 9,
  parameter int NIN = 12,
  parameter logic [7:0] OUT_BASE = 8'h01,
  parameter logic [7:0] CLAMP_LO = 8'h1D,
  parameter logic [7:0] CLAMP_HI = 8'h1E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic [NOUT*NIN-1:0]  sel_onehot,
  output logic [NOUT-1:0]      out_en,
  output logic [2*NOUT-1:0]    gain_code,
  output logic [NIN-1:0]       clamp_sel
);
  localparam int HI_W = NIN - 8;
  localparam logic [4:0] MAX_CODE = 5'(NIN);
  localparam logic [NIN-1:0] ONE = {{(NIN-1){1'b0}}, 1'b1};

  logic [NOUT-1:0]   en_q;
  logic [2*NOUT-1:0] gain_q;
  logic [4:0]        code_q [NOUT];
  logic [NIN-1:0]    clamp_q;

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam logic [7:0] ADDR_K = 8'(OUT_BASE + k);
    logic hit;
    logic valid;
    assign hit = wr_en && (wr_addr == ADDR_K);
    assign valid = en_q[k] && (code_q[k] != 5'd0) && (code_q[k] <= MAX_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[k]          <= 1'b0;
        gain_q[2*k +: 2] <= 2'b00;
        code_q[k]        <= 5'd0;
      end else if (hit) begin
        en_q[k]          <= wr_data[7];
        gain_q[2*k +: 2] <= wr_data[6:5];
        code_q[k]        <= wr_data[4:0];
      end
    end

    assign sel_onehot[k*NIN +: NIN] = valid ? (ONE << (code_q[k] - 5'd1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      clamp_q <= '0;
    else if (wr_en && wr_addr == CLAMP_LO)
      clamp_q[7:0] <= wr_data;
    else if (wr_en && wr_addr == CLAMP_HI)
      clamp_q[NIN-1:8] <= wr_data[HI_W-1:0];
  end

  assign out_en    = en_q;
  assign gain_code = gain_q;
  assign clamp_sel = clamp_q;
endmodule

module xpt_route_regs_chk #(
  parameter int NOUT = 9,
  parameter int NIN = 12,
  parameter logic [7:0] OUT_BASE = 8'h01,
  parameter logic [7:0] CLAMP_LO = 8'h1D,
  parameter logic [7:0] CLAMP_HI = 8'h1E
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [7:0]          wr_addr,
  input logic [7:0]          wr_data,
  input logic [NOUT*NIN-1:0] sel_onehot,
  input logic [NOUT-1:0]     out_en,
  input logic [2*NOUT-1:0]   gain_code,
  input logic [NIN-1:0]      clamp_sel
);
  logic defined;
  assign defined = (wr_addr >= OUT_BASE && wr_addr < 8'(OUT_BASE + NOUT)) ||
                   wr_addr == CLAMP_LO || wr_addr == CLAMP_HI;

  for (genvar k = 0; k < NOUT; k++) begin : g_chk
    // R8
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_onehot[k*NIN +: NIN]));
    // R7
    off_row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[k] |-> sel_onehot[k*NIN +: NIN] == '0);
    // R3
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 8'(OUT_BASE + k)) |=> out_en[k] == $past(wr_data[7]));
  end

  // R9
  clamp_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CLAMP_LO) |=> clamp_sel[7:0] == $past(wr_data));
  // R10
  undef_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !defined) |=> ($stable(sel_onehot) && $stable(out_en) &&
                             $stable(gain_code) && $stable(clamp_sel)));
  // R11
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sel_onehot) && $stable(out_en) &&
                $stable(gain_code) && $stable(clamp_sel)));
endmodule

bind xpt_route_regs xpt_route_regs_chk #(
  .NOUT(NOUT), .NIN(NIN), .OUT_BASE(OUT_BASE), .CLAMP_LO(CLAMP_LO), .CLAMP_HI(CLAMP_HI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sel_onehot(sel_onehot), .out_en(out_en), .gain_code(gain_code), .clamp_sel(clamp_sel)
);

// File: tb/xpt_route_regs_tb.sv
`timescale 1ns/1ps
module xpt_route_regs_tb_top;
  localparam int NOUT = 9;
  localparam int NIN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [NOUT*NIN-1:0] sel_onehot;
  logic [NOUT-1:0] out_en;
  logic [2*NOUT-1:0] gain_code;
  logic [NIN-1:0] clamp_sel;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NOUT-1:0] m_en;
  logic [1:0] m_gain [NOUT];
  logic [4:0] m_code [NOUT];
  logic [NIN-1:0] m_clamp;

  always #2.5 clk = ~clk;

  xpt_route_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_onehot(sel_onehot), .out_en(out_en), .gain_code(gain_code), .clamp_sel(clamp_sel)
  );

  task automatic model_clear();
    m_en = '0;
    m_clamp = '0;
    for (int k = 0; k < NOUT; k++) begin
      m_gain[k] = 2'b00;
      m_code[k] = 5'd0;
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h01 && a <= 8'h09) begin
      m_en[a-1] = d[7];
      m_gain[a-1] = d[6:5];
      m_code[a-1] = d[4:0];
    end else if (a == 8'h1D) begin
      m_clamp[7:0] = d;
    end else if (a == 8'h1E) begin
      m_clamp[11:8] = d[3:0];
    end
  endtask

  function automatic logic [NOUT*NIN-1:0] exp_sel();
    logic [NOUT*NIN-1:0] v = '0;
    for (int k = 0; k < NOUT; k++)
      if (m_en[k] && m_code[k] >= 5'd1 && m_code[k] <= 5'd12)
        v[k*NIN + int'(m_code[k]) - 1] = 1'b1;
    return v;
  endfunction

  function automatic logic [2*NOUT-1:0] exp_gain();
    logic [2*NOUT-1:0] v;
    for (int k = 0; k < NOUT; k++) v[2*k +: 2] = m_gain[k];
    return v;
  endfunction

  task automatic check(input string req);
    n_tests++;
    if (sel_onehot !== exp_sel() || out_en !== m_en ||
        gain_code !== exp_gain() || clamp_sel !== m_clamp) begin
      n_fail++;
      $display("FAIL %s: sel=%h en=%b gain=%b clamp=%h expected sel=%h en=%b gain=%b clamp=%h",
               req, sel_onehot, out_en, gain_code, clamp_sel,
               exp_sel(), m_en, exp_gain(), m_clamp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic t_reset();
    model_clear();
    @(negedge clk);
    check("R1 reset state");
  endtask

  task automatic t_route();
    wr(8'h01, 8'h83);
    check("R2 R5 output1 input3");
    wr(8'h09, 8'h8C);
    check("R5 output9 input12");
    wr(8'h05, 8'h81);
    check("R5 output5 input1");
  endtask

  task automatic t_gain();
    for (int g = 0; g < 4; g++) begin
      wr(8'h09, {1'b1, 2'(g), 5'd7});
      check("R4 gain code");
    end
    wr(8'h03, 8'h80);
    check("R3 enable with no input");
  endtask

  task automatic t_disable_same_cycle();
    wr(8'h04, 8'h45);
    check("R7 R4 disabled with valid code");
    wr(8'h06, 8'h0C);
    check("R7 disabled code12");
    wr(8'h06, 8'h8C);
    check("R7 re-enable shows route");
    wr(8'h06, 8'h2C);
    check("R7 R3 power down clears row");
  endtask

  task automatic t_bad_codes();
    logic [4:0] codes [4] = '{5'd0, 5'd13, 5'd16, 5'd31};
    foreach (codes[i]) begin
      wr(8'h02, {3'b111, codes[i]});
      check("R6 out-of-range code");
    end
    wr(8'h02, 8'h9C);
    check("R6 bit4 set with code12 low bits");
  endtask

  task automatic t_fanout();
    wr(8'h02, 8'h8C);
    wr(8'h03, 8'hAC);
    wr(8'h07, 8'hCC);
    check("R8 three outputs share input12");
  endtask

  task automatic t_clamp();
    wr(8'h1D, 8'hA5);
    check("R9 clamp inputs 1-8");
    wr(8'h1E, 8'hFF);
    check("R9 clamp inputs 9-12 upper ignored");
    wr(8'h1E, 8'hF6);
    check("R9 clamp high rewrite");
  endtask

  task automatic t_undef();
    logic [7:0] addrs [6] = '{8'h00, 8'h0A, 8'h1C, 8'h1F, 8'h80, 8'hFF};
    foreach (addrs[i]) begin
      wr(addrs[i], 8'hFF);
      check("R10 undefined address ignored");
    end
  endtask

  task automatic t_nostrobe();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_addr = (i % 2 == 0) ? 8'h1D : 8'(i);
      wr_data = 8'(8'h5A ^ i);
    end
    @(negedge clk);
    check("R11 no strobe no change");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    check("R1 reset mid-run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_gain();
    t_disable_same_cycle();
    t_bad_codes();
    t_fanout();
    t_clamp();
    t_undef();
    t_nostrobe();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule